// File: doc/BRIEF.md
# Tile-Based Game Pixel Renderer

This block produces 640×480, 60 Hz raster timing and the colour of every pixel for a tile-based snake game, with no frame buffer. A divider on the 100 MHz system clock yields a one-cycle pixel tick every fourth cycle. On each tick, free-running column and row counters advance. The two sync outputs are decoded from these counters.

Each visible pixel is coloured as it is scanned. Its tile coordinate is compared in parallel against the head tile, every live body segment, the apple tile and, when enabled, the border walls. A fixed priority resolves overlaps. All object positions are given in tile units: a tile is 2^TILE_LOG2 pixels square, 16×16 by default.

The sync outputs and the colour are registered together on the pixel tick. For that reason they belong to the coordinate that `px`/`py` showed just before the tick.

Top module: `tile_pixel_renderer`

## Requirements
- R1: `pix_tick` is high for exactly one cycle in every CLK_DIV clock cycles. `px`, `py`, `hsync`, `vsync` and `rgb` change only on a clock edge where `pix_tick` was high.
- R2: On each tick, `px` counts 0 to H_ACTIVE+H_FP+H_SYNC+H_BP−1 and wraps to 0. `py` advances by one when `px` wraps and itself wraps after V_ACTIVE+V_FP+V_SYNC+V_BP lines.
- R3: `hsync` is low (active) for pixels whose column lies in [H_ACTIVE+H_FP, H_ACTIVE+H_FP+H_SYNC) and high otherwise.
- R4: `vsync` is low (active) for pixels whose row lies in [V_ACTIVE+V_FP, V_ACTIVE+V_FP+V_SYNC) and high otherwise.
- R5: `rgb` is 0 for any pixel whose column is ≥ H_ACTIVE or whose row is ≥ V_ACTIVE.
- R6: `rgb` packs red in bits 11:8, green in 7:4 and blue in 3:0. Inside the active area a pixel's tile is (column>>TILE_LOG2, row>>TILE_LOG2). Colours are: head tile 12'hFF0 (yellow), live body tile 12'h0F0 (green), apple tile 12'hF00 (red), wall 12'hFFF (white), anything else 12'h000 (black).
- R7: When tiles overlap, the colour follows the priority head, then body, then apple, then wall, then background.
- R8: Only body segment i with i < `snake_len` is matched. Segment i occupies bits [i*XW +: XW] of `body_x` and [i*YW +: YW] of `body_y`. A segment at or beyond the length leaves its tile black unless another object covers it.
- R9: With `wall_en` high, every tile in the first or last tile column or the first or last tile row is a wall. With `wall_en` low, no tile is a wall.
- R10: While `rst_n` is low, `px` and `py` are 0, both syncs are high, `rgb` is 0 and `pix_tick` is low.
- R11: The `hsync`, `vsync` and `rgb` values present after a tick edge all belong to the coordinate that `px`/`py` held before that edge, so sync and colour share one pipeline latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| head_x | input | XW | Head tile column |
| head_y | input | YW | Head tile row |
| body_x | input | MAX_SEG*XW | Packed body segment tile columns, segment 0 in the low bits |
| body_y | input | MAX_SEG*YW | Packed body segment tile rows, segment 0 in the low bits |
| snake_len | input | LW | Number of live body segments, 0..MAX_SEG |
| apple_x | input | XW | Apple tile column |
| apple_y | input | YW | Apple tile row |
| wall_en | input | 1 | Enables the border walls |
| pix_tick | output | 1 | Pixel enable, one cycle in CLK_DIV |
| px | output | HW | Current scan column |
| py | output | VW | Current scan row |
| hsync | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active low |
| rgb | output | 12 | Pixel colour, 4 bits per channel |

## Verification
The bench builds the renderer with the following configuration:
- a 32×24 active area;
- horizontal porch/sync/porch of 2/3/3 and vertical of 1/2/2, giving a 40×29 raster;
- 4-pixel tiles, giving an 8×6 tile grid;
- four body segments;
- a divide-by-3 tick.

This configuration lets it compare every pixel of several whole frames against arithmetic expectations. The scenes cover:
- every blanking edge and both sync windows;
- every border tile with walls on and off;
- body lengths of 0, 2 and the maximum;
- overlaps between every pair of neighbouring priority levels.

// File: rtl/tile_pixel_renderer.sv
module tile_pixel_renderer #(
  parameter int CLK_DIV   = 4,
  parameter int H_ACTIVE  = 640,
  parameter int H_FP      = 16,
  parameter int H_SYNC    = 96,
  parameter int H_BP      = 48,
  parameter int V_ACTIVE  = 480,
  parameter int V_FP      = 10,
  parameter int V_SYNC    = 2,
  parameter int V_BP      = 33,
  parameter int TILE_LOG2 = 4,
  parameter int MAX_SEG   = 16,
  localparam int H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HW       = $clog2(H_TOTAL),
  localparam int VW       = $clog2(V_TOTAL),
  localparam int TX_N     = H_ACTIVE >> TILE_LOG2,
  localparam int TY_N     = V_ACTIVE >> TILE_LOG2,
  localparam int XW       = (TX_N > 1) ? $clog2(TX_N) : 1,
  localparam int YW       = (TY_N > 1) ? $clog2(TY_N) : 1,
  localparam int LW       = $clog2(MAX_SEG + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [XW-1:0]         head_x,
  input  logic [YW-1:0]         head_y,
  input  logic [MAX_SEG*XW-1:0] body_x,
  input  logic [MAX_SEG*YW-1:0] body_y,
  input  logic [LW-1:0]         snake_len,
  input  logic [XW-1:0]         apple_x,
  input  logic [YW-1:0]         apple_y,
  input  logic                  wall_en,
  output logic                  pix_tick,
  output logic [HW-1:0]         px,
  output logic [VW-1:0]         py,
  output logic                  hsync,
  output logic                  vsync,
  output logic [11:0]           rgb
);

  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [11:0] C_HEAD  = 12'hFF0;
  localparam logic [11:0] C_BODY  = 12'h0F0;
  localparam logic [11:0] C_APPLE = 12'hF00;
  localparam logic [11:0] C_WALL  = 12'hFFF;

  logic [DW-1:0] div;

  assign pix_tick = rst_n && (div == DW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        div <= '0;
    else if (pix_tick) div <= '0;
    else               div <= div + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px <= '0;
      py <= '0;
    end else if (pix_tick) begin
      if (px == HW'(H_TOTAL - 1)) begin
        px <= '0;
        py <= (py == VW'(V_TOTAL - 1)) ? '0 : py + 1'b1;
      end else begin
        px <= px + 1'b1;
      end
    end
  end

  logic [XW-1:0] tx;
  logic [YW-1:0] ty;
  assign tx = XW'(px >> TILE_LOG2);
  assign ty = YW'(py >> TILE_LOG2);

  logic [MAX_SEG-1:0] seg_hit;
  for (genvar i = 0; i < MAX_SEG; i++) begin : g_seg
    assign seg_hit[i] = (LW'(i) < snake_len) &&
                        (body_x[i*XW +: XW] == tx) &&
                        (body_y[i*YW +: YW] == ty);
  end

  logic active, head_hit, body_hit, apple_hit, wall_hit;
  assign active    = (px < HW'(H_ACTIVE)) && (py < VW'(V_ACTIVE));
  assign head_hit  = (head_x == tx) && (head_y == ty);
  assign body_hit  = |seg_hit;
  assign apple_hit = (apple_x == tx) && (apple_y == ty);
  assign wall_hit  = wall_en && (tx == '0 || tx == XW'(TX_N - 1) ||
                                 ty == '0 || ty == YW'(TY_N - 1));

  logic [11:0] color;
  always_comb begin
    if (!active)        color = '0;
    else if (head_hit)  color = C_HEAD;
    else if (body_hit)  color = C_BODY;
    else if (apple_hit) color = C_APPLE;
    else if (wall_hit)  color = C_WALL;
    else                color = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync <= 1'b1;
      vsync <= 1'b1;
      rgb   <= '0;
    end else if (pix_tick) begin
      hsync <= !((px >= HW'(H_ACTIVE + H_FP)) && (px < HW'(H_ACTIVE + H_FP + H_SYNC)));
      vsync <= !((py >= VW'(V_ACTIVE + V_FP)) && (py < VW'(V_ACTIVE + V_FP + V_SYNC)));
      rgb   <= color;
    end
  end

endmodule

// File: rtl/tile_pixel_renderer_chk.sv
module tile_pixel_renderer_chk #(
  parameter int CLK_DIV  = 4,
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_tick,
  input logic [HW-1:0] px,
  input logic [VW-1:0] py,
  input logic          hsync,
  input logic          vsync,
  input logic [11:0]   rgb
);

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (CLK_DIV > 1) && pix_tick |=> !pix_tick);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_tick |=> $stable(px) && $stable(py) && $stable(hsync) && $stable(vsync) && $stable(rgb));

  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (px < HW'(H_TOTAL)) && (py < VW'(V_TOTAL)));

  p_hwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_tick && (px == HW'(H_TOTAL - 1)) |=> (px == '0));

  p_hsync_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_tick && (px == HW'(H_ACTIVE + H_FP)) |=> !hsync);

  p_vsync_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_tick && (py == VW'(V_ACTIVE + V_FP)) |=> !vsync);

  p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_tick && ((px >= HW'(H_ACTIVE)) || (py >= VW'(V_ACTIVE))) |=> (rgb == '0));

endmodule

bind tile_pixel_renderer tile_pixel_renderer_chk #(
  .CLK_DIV(CLK_DIV), .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
  .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .px(px), .py(py),
  .hsync(hsync), .vsync(vsync), .rgb(rgb)
);

// File: tb/sim_tile_pixel_renderer.sv
module sim_tile_pixel_renderer;

  localparam int CD = 3;
  localparam int HA = 32, HF = 2, HS = 3, HB = 3;
  localparam int VA = 24, VF = 1, VS = 2, VB = 2;
  localparam int TL = 2, NS = 4;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int XN = HA >> TL, YN = VA >> TL;
  localparam int XW = 3, YW = 3, LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [XW-1:0] head_x = '0, apple_x = '0;
  logic [YW-1:0] head_y = '0, apple_y = '0;
  logic [NS*XW-1:0] body_x = '0;
  logic [NS*YW-1:0] body_y = '0;
  logic [LW-1:0] snake_len = '0;
  logic wall_en = 1'b0;
  logic pix_tick, hsync, vsync;
  logic [5:0] px;
  logic [4:0] py;
  logic [11:0] rgb;

  always #2.5 clk = ~clk;

  tile_pixel_renderer #(
    .CLK_DIV(CD), .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .TILE_LOG2(TL), .MAX_SEG(NS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .head_x(head_x), .head_y(head_y),
    .body_x(body_x), .body_y(body_y), .snake_len(snake_len),
    .apple_x(apple_x), .apple_y(apple_y), .wall_en(wall_en),
    .pix_tick(pix_tick), .px(px), .py(py), .hsync(hsync), .vsync(vsync), .rgb(rgb)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_rgb(int x, int y, output string tag);
    int tx = x >> TL, ty = y >> TL;
    bit h, b, a, w, gone;
    if (x >= HA || y >= VA) begin tag = "R5"; return 12'h000; end
    h = (int'(head_x) == tx) && (int'(head_y) == ty);
    b = 0; gone = 0;
    for (int i = 0; i < NS; i++)
      if (int'(body_x[i*XW +: XW]) == tx && int'(body_y[i*YW +: YW]) == ty) begin
        if (i < int'(snake_len)) b = 1; else gone = 1;
      end
    a = (int'(apple_x) == tx) && (int'(apple_y) == ty);
    w = wall_en && (tx == 0 || tx == XN - 1 || ty == 0 || ty == YN - 1);
    if (h) begin tag = (b || a || w) ? "R7" : "R6"; return 12'hFF0; end
    if (b) begin tag = (a || w) ? "R7" : "R6"; return 12'h0F0; end
    if (gone && !a) begin tag = "R8"; return w ? 12'hFFF : 12'h000; end
    if (a) begin tag = w ? "R7" : "R6"; return 12'hF00; end
    if (w) begin tag = "R9"; return 12'hFFF; end
    tag = wall_en ? "R6" : "R9";
    return 12'h000;
  endfunction

  task automatic set_seg(int i, int x, int y);
    body_x[i*XW +: XW] = XW'(x);
    body_y[i*YW +: YW] = YW'(y);
  endtask

  task automatic setup(int s);
    case (s)
      0: begin
        wall_en = 1; head_x = 3; head_y = 2; snake_len = 2;
        set_seg(0, 3, 2); set_seg(1, 4, 2); set_seg(2, 5, 2); set_seg(3, 6, 3);
        apple_x = 4; apple_y = 2;
      end
      1: begin
        wall_en = 0; head_x = 0; head_y = 0; snake_len = 4;
        set_seg(0, 1, 1); set_seg(1, 2, 1); set_seg(2, 7, 5); set_seg(3, 0, 5);
        apple_x = 7; apple_y = 0;
      end
      default: begin
        wall_en = 1; head_x = 7; head_y = 5; snake_len = 0;
        set_seg(0, 2, 2); set_seg(1, 3, 3); set_seg(2, 0, 1); set_seg(3, 4, 4);
        apple_x = 0; apple_y = 3;
      end
    endcase
  endtask

  initial begin
    int prev_x = 0, prev_y = 0, last_tick = 0;
    bit have_prev = 0;
    string tag;
    logic [11:0] e;
    repeat (4) @(negedge clk);
    chk("R10", "px", int'(px), 0);
    chk("R10", "py", int'(py), 0);
    chk("R10", "hsync", int'(hsync), 1);
    chk("R10", "vsync", int'(vsync), 1);
    chk("R10", "rgb", int'(rgb), 0);
    chk("R10", "pix_tick", int'(pix_tick), 0);
    rst_n = 1'b1;
    for (int s = 0; s < 3; s++) begin
      setup(s);
      for (int p = 0; p < HT * VT + 2; p++) begin
        do begin @(negedge clk); cyc++; end while (!pix_tick);
        if (last_tick != 0) chk("R1", "tick spacing", cyc - last_tick, CD);
        last_tick = cyc;
        if (have_prev) begin
          e = exp_rgb(prev_x, prev_y, tag);
          chk(tag, "rgb", int'(rgb), int'(e));
          chk(prev_x == HA + HF ? "R11" : "R3", "hsync", int'(hsync),
              (prev_x >= HA + HF && prev_x < HA + HF + HS) ? 0 : 1);
          chk("R4", "vsync", int'(vsync),
              (prev_y >= VA + VF && prev_y < VA + VF + VS) ? 0 : 1);
          chk("R2", "px", int'(px), (prev_x + 1) % HT);
          chk("R2", "py", int'(py), (prev_x == HT - 1) ? (prev_y + 1) % VT : prev_y);
        end else begin
          chk("R2", "first px", int'(px), 0);
        end
        prev_x = int'(px);
        prev_y = int'(py);
        have_prev = 1;
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule